// File: doc/BRIEF.md
# Shared Global Timer with Per-Core Compare Channels

One free-running 64-bit up-counter serves several processor cores. Each core has its own compare channel and its own interrupt line. The counter advances by one on every (prescale+1)-th clock, but only while the global run bit is set. Each core owns a 64-bit comparator. When the counter has reached or passed that comparator, the core's status flag is raised. If the core has asked for it, the comparator is then pushed forward by a 32-bit step, so the channel fires periodically.

Cores reach the block through a simple single-cycle register bus. Every access carries a core index, which picks that core's banked registers inside an eight-word (32-byte) window of 32-bit registers.

The word index is `bus_addr[4:2]`:

| Index | Byte offset | Register |
|---|---|---|
| 0 | 0x00 | counter bits 31:0 |
| 1 | 0x04 | counter bits 63:32 |
| 2 | 0x08 | control |
| 3 | 0x0C | status |
| 4 | 0x10 | comparator bits 31:0 |
| 5 | 0x14 | comparator bits 63:32 |
| 6 | 0x18 | step value |
| 7 | 0x1C | reads zero |

The control word uses these bit positions:

| Bits | Field | Scope |
|---|---|---|
| 0 | run | global |
| 1 | compare enable | banked per core |
| 2 | interrupt enable | banked per core |
| 3 | auto-step | banked per core |
| 15:8 | prescale | global |

Software stops the timer before it loads the counter. The counter is written as two halves.

Top module: `gt_global_timer`

## Requirements
- R1: While the run bit (control bit 0) is clear, a write to index 0 loads counter bits 31:0 and a write to index 1 loads bits 63:32. Reads of those indices return the matching half, and a carry out of the low half reaches the high half.
- R2: While run is set, the counter increments exactly once every (P+1) clocks, where P is control bits 15:8. While run is clear, the counter holds.
- R3: A counter write made while run is set is ignored, and counting continues undisturbed.
- R4: A core's status flag (status bit 0) becomes 1 in the clock after a cycle in which run, that core's compare enable (bit 1) and counter >= that core's comparator all hold. Otherwise it holds its value unless it is cleared.
- R5: When a compare event occurs and the core's auto-step bit (bit 3) is set, the comparator grows by that core's 32-bit step value (index 6). A comparator write in the same cycle takes precedence.
- R6: Each core's interrupt output equals its status flag ANDed with its interrupt enable (bit 2).
- R7: Writing status with bit 0 = 1 clears the writing core's flag, and writing 0 leaves it unchanged. A compare event in the same cycle wins, and the flag stays 1.
- R8: A control write updates the global fields (run, prescale) for all cores and the banked fields of the writing core only. A control read returns the global fields ORed with the reader's banked fields.
- R9: A synchronous active-high reset clears the counter, the prescale phase, the global fields, and every core's comparator, step value, status flag and banked fields.
- R10: Index 7 reads zero. An access whose core index is not below the configured core count has no effect on writes and reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_core | input | 2 | Index of the requesting core |
| bus_addr | input | 5 | Byte offset in the window; bits 4:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address, core index and state |
| irq | output | NCORES | Per-core interrupt lines |

## Verification
The assertions are checked on every cycle and cover local cause and effect:
- the prescaler never ticks twice in a row while the prescale value is nonzero;
- the counter holds without a tick and is not disturbed by a write while running;
- a compare hit raises the flag in the next cycle;
- a write-one clear without a hit drops the flag;
- an auto-step adds exactly the step value;
- a write from an out-of-range core leaves the global fields untouched.

Other behaviour only shows up in the bench's scenarios, where a behavioural reference model is compared against every read and every interrupt line on each clock:
- the exact spacing of ticks after a prescale change;
- the carry from the low counter half into the high half;
- the periodic firing pattern of several channels running side by side;
- the read-back ORing of banked and global control fields.

// File: rtl/gt_pkg.sv
package gt_pkg;
    localparam int MAX_CORES = 4;
    localparam int CORE_W    = $clog2(MAX_CORES);
    localparam int WORD_W    = 32;
    localparam int CNT_W     = 2 * WORD_W;
    localparam int PRE_W     = 8;
    localparam int ADDR_W    = 5;

    localparam int BIT_RUN   = 0;
    localparam int BIT_CMP   = 1;
    localparam int BIT_IRQ   = 2;
    localparam int BIT_AUTO  = 3;
    localparam int PRE_LSB   = 8;

    typedef enum logic [2:0] {
        IDX_CNT_LO = 3'd0,
        IDX_CNT_HI = 3'd1,
        IDX_CTRL   = 3'd2,
        IDX_STAT   = 3'd3,
        IDX_CMP_LO = 3'd4,
        IDX_CMP_HI = 3'd5,
        IDX_STEP   = 3'd6,
        IDX_NONE   = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic auto_step;
        logic irq_en;
        logic cmp_en;
    } bank_ctrl_t;

    typedef struct packed {
        logic [PRE_W-1:0] prescale;
        logic             run;
    } glob_ctrl_t;

    function automatic bank_ctrl_t bank_from_word(input logic [WORD_W-1:0] w);
        bank_ctrl_t b;
        b.auto_step = w[BIT_AUTO];
        b.irq_en    = w[BIT_IRQ];
        b.cmp_en    = w[BIT_CMP];
        return b;
    endfunction

    function automatic glob_ctrl_t glob_from_word(input logic [WORD_W-1:0] w);
        glob_ctrl_t g;
        g.run      = w[BIT_RUN];
        g.prescale = w[PRE_LSB +: PRE_W];
        return g;
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_word(input glob_ctrl_t g, input bank_ctrl_t b);
        logic [WORD_W-1:0] w;
        w                    = '0;
        w[BIT_RUN]           = g.run;
        w[PRE_LSB +: PRE_W]  = g.prescale;
        w[BIT_CMP]           = b.cmp_en;
        w[BIT_IRQ]           = b.irq_en;
        w[BIT_AUTO]          = b.auto_step;
        return w;
    endfunction
endpackage

// File: rtl/gt_prescaler.sv
module gt_prescaler
    import gt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PRE_W-1:0] prescale,
    output logic             tick
);
    logic [PRE_W-1:0] phase;

    assign tick = run && (phase == prescale);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase <= '0;
        end else if (tick) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // R2: with a nonzero prescale two ticks never come back to back
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && prescale != '0) |=> (!tick || prescale == '0));
endmodule

// File: rtl/gt_counter.sv
module gt_counter
    import gt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              tick,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!run && wr_lo) begin
            cnt[WORD_W-1:0] <= wdata;
        end else if (!run && wr_hi) begin
            cnt[CNT_W-1:WORD_W] <= wdata;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2: no tick and no load means the count holds
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_lo && !wr_hi) |=> $stable(cnt));

    // R3: a write while running changes nothing beyond the normal tick
    p_locked_r3: assert property (@(posedge clk) disable iff (rst)
        (run && (wr_lo || wr_hi)) |=> (cnt == $past(cnt) + {{(CNT_W-1){1'b0}}, $past(tick)}));
endmodule

// File: rtl/gt_channel.sv
module gt_channel
    import gt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              wr_ctrl,
    input  logic              wr_stat,
    input  logic              wr_cmp_lo,
    input  logic              wr_cmp_hi,
    input  logic              wr_step,
    input  logic [WORD_W-1:0] wdata,
    output bank_ctrl_t        bank,
    output logic              status,
    output logic [CNT_W-1:0]  cmp,
    output logic [WORD_W-1:0] step,
    output logic              irq
);
    logic hit;
    logic clr;

    assign hit = run && bank.cmp_en && (cnt >= cmp);
    assign clr = wr_stat && wdata[0];
    assign irq = status && bank.irq_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank   <= '0;
            status <= 1'b0;
            cmp    <= '0;
            step   <= '0;
        end else begin
            if (wr_ctrl) begin
                bank <= bank_from_word(wdata);
            end
            if (wr_step) begin
                step <= wdata;
            end
            if (hit) begin
                status <= 1'b1;
            end else if (clr) begin
                status <= 1'b0;
            end
            if (wr_cmp_lo) begin
                cmp[WORD_W-1:0] <= wdata;
            end else if (wr_cmp_hi) begin
                cmp[CNT_W-1:WORD_W] <= wdata;
            end else if (hit && bank.auto_step) begin
                cmp <= cmp + {{(CNT_W-WORD_W){1'b0}}, step};
            end
        end
    end

    // R4: a hit raises the flag in the next cycle
    p_hit_sets_r4: assert property (@(posedge clk) disable iff (rst)
        hit |=> status);

    // R4: without a hit or a clear the flag holds
    p_flag_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (!hit && !clr) |=> (status == $past(status)));

    // R7: a write-one clear without a competing hit drops the flag
    p_w1c_r7: assert property (@(posedge clk) disable iff (rst)
        (clr && !hit) |=> !status);

    // R5: an auto-step adds exactly the step value
    p_autostep_r5: assert property (@(posedge clk) disable iff (rst)
        (hit && bank.auto_step && !wr_cmp_lo && !wr_cmp_hi)
        |=> (cmp == $past(cmp) + {{(CNT_W-WORD_W){1'b0}}, $past(step)}));
endmodule

// File: rtl/gt_global_timer.sv
module gt_global_timer
    import gt_pkg::*;
#(
    parameter int NCORES = MAX_CORES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [CORE_W-1:0] bus_core,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [NCORES-1:0] irq
);
    glob_ctrl_t        glob;
    logic              tick;
    logic [CNT_W-1:0]  cnt;
    logic              core_ok;
    logic              wr_ok;
    reg_idx_e          idx;

    bank_ctrl_t        ch_bank   [NCORES];
    logic              ch_status [NCORES];
    logic [CNT_W-1:0]  ch_cmp    [NCORES];
    logic [WORD_W-1:0] ch_step   [NCORES];

    assign core_ok = int'(bus_core) < NCORES;
    assign wr_ok   = bus_sel && bus_wr && core_ok;
    assign idx     = reg_idx_e'(bus_addr[ADDR_W-1:2]);

    always_ff @(posedge clk) begin
        if (rst) begin
            glob <= '0;
        end else if (wr_ok && idx == IDX_CTRL) begin
            glob <= glob_from_word(bus_wdata);
        end
    end

    gt_prescaler u_pre (
        .clk      (clk),
        .rst      (rst),
        .run      (glob.run),
        .prescale (glob.prescale),
        .tick     (tick)
    );

    gt_counter u_cnt (
        .clk   (clk),
        .rst   (rst),
        .run   (glob.run),
        .tick  (tick),
        .wr_lo (wr_ok && idx == IDX_CNT_LO),
        .wr_hi (wr_ok && idx == IDX_CNT_HI),
        .wdata (bus_wdata),
        .cnt   (cnt)
    );

    for (genvar i = 0; i < NCORES; i++) begin : g_ch
        logic mine;
        assign mine = wr_ok && (int'(bus_core) == i);

        gt_channel u_ch (
            .clk       (clk),
            .rst       (rst),
            .run       (glob.run),
            .cnt       (cnt),
            .wr_ctrl   (mine && idx == IDX_CTRL),
            .wr_stat   (mine && idx == IDX_STAT),
            .wr_cmp_lo (mine && idx == IDX_CMP_LO),
            .wr_cmp_hi (mine && idx == IDX_CMP_HI),
            .wr_step   (mine && idx == IDX_STEP),
            .wdata     (bus_wdata),
            .bank      (ch_bank[i]),
            .status    (ch_status[i]),
            .cmp       (ch_cmp[i]),
            .step      (ch_step[i]),
            .irq       (irq[i])
        );
    end

    always_comb begin
        bank_ctrl_t        s_bank;
        logic              s_status;
        logic [CNT_W-1:0]  s_cmp;
        logic [WORD_W-1:0] s_step;
        s_bank   = '0;
        s_status = 1'b0;
        s_cmp    = '0;
        s_step   = '0;
        for (int i = 0; i < NCORES; i++) begin
            if (int'(bus_core) == i) begin
                s_bank   = ch_bank[i];
                s_status = ch_status[i];
                s_cmp    = ch_cmp[i];
                s_step   = ch_step[i];
            end
        end
        bus_rdata = '0;
        if (core_ok) begin
            case (idx)
                IDX_CNT_LO: bus_rdata = cnt[WORD_W-1:0];
                IDX_CNT_HI: bus_rdata = cnt[CNT_W-1:WORD_W];
                IDX_CTRL:   bus_rdata = ctrl_word(glob, s_bank);
                IDX_STAT:   bus_rdata = {{(WORD_W-1){1'b0}}, s_status};
                IDX_CMP_LO: bus_rdata = s_cmp[WORD_W-1:0];
                IDX_CMP_HI: bus_rdata = s_cmp[CNT_W-1:WORD_W];
                IDX_STEP:   bus_rdata = s_step;
                default:    bus_rdata = '0;
            endcase
        end
    end

    // R10: a write from a core index outside the configured set leaves the global fields alone
    p_bad_core_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && !core_ok) |=> $stable(glob));

    initial begin
        assert (NCORES >= 1 && NCORES <= MAX_CORES)
            else $error("NCORES out of range");
    end
endmodule

// File: tb/tb_gt_global_timer.sv
module tb_gt_global_timer;
    localparam int NC = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_core = '0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NC-1:0] irq;

    always #2 clk = ~clk;

    gt_global_timer #(.NCORES(NC)) dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_core(bus_core), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    int nchk = 0;
    int nfail = 0;
    bit started = 0;

    // behavioural reference state
    logic [63:0] mcnt;
    logic [7:0]  mpsc, mpre;
    logic        men;
    logic [63:0] mcmp [NC];
    logic [31:0] mstep [NC];
    logic        mst [NC], mce [NC], mie [NC], mai [NC];
    logic        ev [NC];
    logic        tk, wok;
    logic [2:0]  widx;

    function automatic logic [31:0] mctl(input int c);
        return {16'd0, mpre, 4'd0, mai[c], mie[c], mce[c], men};
    endfunction

    function automatic logic [31:0] mread(input logic [4:0] a, input logic [1:0] c);
        int ci;
        ci = int'(c);
        if (ci >= NC) return 32'd0;
        case (a[4:2])
            3'd0: return mcnt[31:0];
            3'd1: return mcnt[63:32];
            3'd2: return mctl(ci);
            3'd3: return {31'd0, mst[ci]};
            3'd4: return mcmp[ci][31:0];
            3'd5: return mcmp[ci][63:32];
            3'd6: return mstep[ci];
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            mcnt = '0; mpsc = '0; mpre = '0; men = 1'b0;
            for (int i = 0; i < NC; i++) begin
                mcmp[i] = '0; mstep[i] = '0; mst[i] = 0; mce[i] = 0; mie[i] = 0; mai[i] = 0;
            end
        end else begin
            tk   = men && (mpsc == mpre);
            wok  = bus_sel && bus_wr && (int'(bus_core) < NC);
            widx = bus_addr[4:2];
            for (int i = 0; i < NC; i++) ev[i] = men && mce[i] && (mcnt >= mcmp[i]);
            if (!men || tk) mpsc = 8'd0; else mpsc = mpsc + 8'd1;
            if (wok && !men && widx == 3'd0)      mcnt[31:0]  = bus_wdata;
            else if (wok && !men && widx == 3'd1) mcnt[63:32] = bus_wdata;
            else if (tk)                           mcnt = mcnt + 64'd1;
            for (int i = 0; i < NC; i++) begin
                bit me;
                me = wok && (int'(bus_core) == i);
                if (ev[i]) mst[i] = 1;
                else if (me && widx == 3'd3 && bus_wdata[0]) mst[i] = 0;
                if (me && widx == 3'd4)      mcmp[i][31:0]  = bus_wdata;
                else if (me && widx == 3'd5) mcmp[i][63:32] = bus_wdata;
                else if (ev[i] && mai[i])    mcmp[i] = mcmp[i] + {32'd0, mstep[i]};
                if (me && widx == 3'd6) mstep[i] = bus_wdata;
                if (me && widx == 3'd2) begin
                    mce[i] = bus_wdata[1]; mie[i] = bus_wdata[2]; mai[i] = bus_wdata[3];
                end
            end
            if (wok && widx == 3'd2) begin
                men  = bus_wdata[0];
                mpre = bus_wdata[15:8];
            end
        end
    end

    function automatic string tag_for(input logic [4:0] a);
        case (a[4:2])
            3'd0, 3'd1: return "R2";
            3'd2:       return "R8";
            3'd3:       return "R4";
            3'd4, 3'd5, 3'd6: return "R5";
            default:    return "R10";
        endcase
    endfunction

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        #1;
        if (started) begin
            logic [31:0] e;
            e = mread(bus_addr, bus_core);
            nchk++;
            if (bus_rdata !== e) begin
                nfail++;
                $display("FAIL %s rdata core=%0d addr=%0h actual=%h expected=%h",
                         tag_for(bus_addr), bus_core, bus_addr, bus_rdata, e);
            end
            for (int i = 0; i < NC; i++) begin
                nchk++;
                if (irq[i] !== (mst[i] && mie[i])) begin
                    nfail++;
                    $display("FAIL R6 irq[%0d] actual=%b expected=%b", i, irq[i], mst[i] && mie[i]);
                end
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input int c, input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_core = 2'(c); bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input int c, input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_core = 2'(c); bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] ctl(input bit en, input bit ce, input bit ie, input bit ai, input logic [7:0] p);
        return {16'd0, p, 4'd0, ai, ie, ce, en};
    endfunction

    task automatic idle_reads(input int n);
        logic [31:0] d;
        for (int k = 0; k < n; k++) rd(k % 3, 5'((k % 8) * 4), d);
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 0;
        rd(0, 5'h08, d); check("R9 control after reset", d, 32'h0);
        rd(0, 5'h00, d); check("R9 counter after reset", d, 32'h0);
        rd(1, 5'h0C, d); check("R9 status after reset", d, 32'h0);
        rd(2, 5'h10, d); check("R9 comparator after reset", d, 32'h0);

        wr(0, 5'h00, 32'hFFFF_FFF0);
        wr(0, 5'h04, 32'h0000_0001);
        rd(0, 5'h00, d); check("R1 counter low load", d, 32'hFFFF_FFF0);
        rd(1, 5'h04, d); check("R1 counter high load", d, 32'h0000_0001);
        rd(0, 5'h1C, d); check("R10 unmapped index", d, 32'h0);
        wr(3, 5'h08, ctl(1, 1, 1, 1, 8'h05));
        rd(0, 5'h08, d); check("R10 bad core write ignored", d, 32'h0);
        rd(3, 5'h08, d); check("R10 bad core reads zero", d, 32'h0);

        wr(0, 5'h10, 32'h0000_000E);
        wr(0, 5'h14, 32'h0000_0002);
        wr(0, 5'h18, 32'd12);
        wr(1, 5'h10, 32'h0000_0040);
        wr(1, 5'h14, 32'h0000_0002);
        wr(1, 5'h08, ctl(0, 1, 1, 0, 8'h00));
        wr(2, 5'h08, ctl(0, 1, 1, 0, 8'h00));
        wr(0, 5'h08, ctl(1, 1, 1, 1, 8'h01));
        rd(1, 5'h08, d); check("R8 global ORed with core1 bank", d, 32'h0000_0107);
        rd(0, 5'h08, d); check("R8 global ORed with core0 bank", d, 32'h0000_010F);
        idle_reads(150);

        rd(0, 5'h04, d); check("R1 carry into high half", d, 32'h0000_0002);
        wr(0, 5'h04, 32'h0000_DEAD);
        rd(0, 5'h04, d); check("R3 running counter write ignored", d, 32'h0000_0002);

        wr(2, 5'h08, ctl(1, 0, 1, 0, 8'h01));
        wr(2, 5'h0C, 32'h1);
        rd(2, 5'h0C, d); check("R7 write-one clears flag", d, 32'h0);
        check("R6 irq follows cleared flag", {31'd0, irq[2]}, 32'h0);
        idle_reads(200);
        rd(1, 5'h0C, d); check("R4 core1 flag after reaching comparator", d, 32'h1);
        wr(1, 5'h0C, 32'h0);
        rd(1, 5'h0C, d); check("R7 writing zero keeps flag", d, 32'h1);
        wr(1, 5'h0C, 32'h1);

        wr(0, 5'h08, ctl(1, 1, 1, 1, 8'h03));
        idle_reads(200);
        wr(0, 5'h08, ctl(0, 1, 1, 1, 8'h03));
        wr(0, 5'h00, 32'd5);
        rd(0, 5'h00, d); check("R1 load after stop", d, 32'd5);
        wr(0, 5'h08, ctl(1, 1, 0, 1, 8'h00));
        idle_reads(60);

        @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        rd(1, 5'h10, d); check("R9 comparator cleared", d, 32'h0);
        rd(0, 5'h18, d); check("R9 step cleared", d, 32'h0);
        rd(0, 5'h08, d); check("R9 control cleared", d, 32'h0);
        rd(0, 5'h04, d); check("R9 counter cleared", d, 32'h0);
        idle_reads(4);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule